// File: doc/BRIEF.md
# Conversion Sequence Controller with Clock-Ratio Mode Detection

This block schedules one sample period of a combined 13-bit converter. A convert clock and a slower sample-sync clock enter as level inputs and are sampled on the system clock. The block counts the convert-clock rising edges in each sync period and picks an operating mode from that count: 32 edges gives full operation (conversion in both directions), 24 gives conversion from analog to digital only, and 8 gives conversion from digital to analog only. A mode is accepted only when two consecutive complete periods give the same count. Until then, and after any other count, the mode is "none" and no strobe is issued.

In a period with a valid mode, the block issues single-cycle strobes. These cover the input sample, thirteen successive-approximation steps, the transmit latch update, the analog output update and the receive latch load. The comparator decision arrives as one bit and is written into an internal approximation register, sign bit first. The finished 13-bit two's-complement word is presented at the transmit latch output.

A low level on the run input halts everything at once. Once run returns high, two complete sync periods must pass before strobes resume.

Top module: `conv_seq_ctl`

## Requirements
- R1: While reset is held and just after it, mode reads 0 (none), and every strobe, tx_ok and tx_word read 0.
- R2: Mode codes are 0 none, 1 full (32 convert clocks), 2 A/D only (24), 3 D/A only (8). The code changes only in the cycle after a sync rising edge, and only when the two complete periods ended by that edge and the previous one had the same valid count.
- R3: A period count other than 32, 24 or 8, or two unequal counts, sets mode 0. No strobe is issued in the period that follows, and tx_ok is 0.
- R4: In modes 1 and 2, smp_stb pulses once per period, in the cycle after the convert rising edge that coincides with the sync rising edge.
- R5: In modes 1 and 2, step_stb pulses after each of the first 13 convert falling edges of the period. On falling edge k, step_bit is 13-k. The comparator bit on that edge is stored as bit 13-k of the approximation word, so bit 12 (the sign) is decided first.
- R6: In modes 1 and 2, tx_load pulses after the last convert rising edge before the next sync (edge 32 or 24). In the same cycle tx_word takes the approximation word and tx_ok goes to 1.
- R7: In modes 1 and 3, aout_upd pulses after the last convert rising edge of the period (edge 32 or 8), and rx_load pulses after the convert falling edge that follows it.
- R8: In mode 2, rx_load and aout_upd never pulse, so received data is ignored.
- R9: In mode 3, smp_stb, step_stb and tx_load never pulse, and tx_ok is 0.
- R10: With run low, mode, tx_ok and all strobes are 0 from the next cycle. After run rises, the first two complete sync periods give no strobes, and the mode returns after the third sync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High for normal operation, low for power-down |
| cvt_clk | input | 1 | Convert clock level |
| sync_clk | input | 1 | Sample-sync clock level |
| cmp_bit | input | 1 | Comparator decision for the current approximation step |
| mode | output | 2 | Accepted mode: 0 none, 1 full, 2 A/D only, 3 D/A only |
| mode_ok | output | 1 | High when mode is not 0 |
| smp_stb | output | 1 | Input sample strobe |
| step_stb | output | 1 | Approximation step strobe |
| step_bit | output | 4 | Bit decided by the current step |
| rx_load | output | 1 | Receive latch load strobe |
| tx_load | output | 1 | Transmit latch update strobe |
| tx_word | output | 13 | Last completed conversion, two's complement |
| tx_ok | output | 1 | Transmit word valid in the current mode |
| aout_upd | output | 1 | Analog output update strobe |

## Verification
The bench steps the sync period through 32, 24, 8 and 20 convert clocks. This shows whether a design adopts a mode after a single period, keeps a stale mode after a count changes, or accepts an illegal count. It includes periods where a valid mode is paired with too few convert clocks, which catches a design that fires the end-of-period strobes on the next sync edge instead of on the counted edge. Walking-bit comparator patterns expose a reversed or shifted approximation order. A mid-run power-down followed by release shows whether a design resumes strobes before two clean periods have elapsed.

// File: rtl/conv_seq_ctl.sv
module conv_seq_ctl #(
  parameter int FULL_N = 32,
  parameter int ADC_N  = 24,
  parameter int DAC_N  = 8,
  parameter int NBITS  = 13,
  parameter int CNT_W  = 6,
  localparam int BIT_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cvt_clk,
  input  logic             sync_clk,
  input  logic             cmp_bit,
  output logic [1:0]       mode,
  output logic             mode_ok,
  output logic             smp_stb,
  output logic             step_stb,
  output logic [BIT_W-1:0] step_bit,
  output logic             rx_load,
  output logic             tx_load,
  output logic [NBITS-1:0] tx_word,
  output logic             tx_ok,
  output logic             aout_upd
);
  localparam logic [1:0] M_NONE = 2'd0, M_FULL = 2'd1, M_ADC = 2'd2, M_DAC = 2'd3;

  logic cvt_q, sync_q, armed;
  logic [CNT_W-1:0] cnt, cnt_nxt, last_n;
  logic [1:0] cls, prev_cls, mode_nxt, mode_sel;
  logic [NBITS-1:0] sar;
  logic [BIT_W-1:0] sidx;

  wire cc_rise = cvt_clk & ~cvt_q;
  wire cc_fall = ~cvt_clk & cvt_q;
  wire sy_rise = sync_clk & ~sync_q;
  wire adc_on  = (mode == M_FULL) || (mode == M_ADC);
  wire dac_on  = (mode == M_FULL) || (mode == M_DAC);
  wire adc_sel = (mode_sel == M_FULL) || (mode_sel == M_ADC);
  wire end_rise = cc_rise && !sy_rise && (cnt_nxt == last_n);
  wire in_steps = (cnt != '0) && (cnt <= CNT_W'(NBITS));

  always_comb begin
    cls = M_NONE;
    if (armed) begin
      if (cnt == CNT_W'(FULL_N))     cls = M_FULL;
      else if (cnt == CNT_W'(ADC_N)) cls = M_ADC;
      else if (cnt == CNT_W'(DAC_N)) cls = M_DAC;
    end
  end

  always_comb begin
    case (mode)
      M_FULL:  last_n = CNT_W'(FULL_N);
      M_ADC:   last_n = CNT_W'(ADC_N);
      M_DAC:   last_n = CNT_W'(DAC_N);
      default: last_n = '0;
    endcase
  end

  assign mode_nxt = (cls != M_NONE && cls == prev_cls) ? cls : M_NONE;
  assign mode_sel = sy_rise ? mode_nxt : mode;
  assign cnt_nxt  = sy_rise ? CNT_W'(cc_rise) :
                    (cnt == '1) ? cnt : cnt + CNT_W'(cc_rise);
  assign sidx     = BIT_W'(NBITS - int'(cnt));
  assign mode_ok  = (mode != M_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cvt_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      cvt_q <= cvt_clk;
      sync_q <= sync_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      armed <= 1'b0;
      prev_cls <= M_NONE;
      mode <= M_NONE;
      smp_stb <= 1'b0;
      step_stb <= 1'b0;
      step_bit <= '0;
      rx_load <= 1'b0;
      tx_load <= 1'b0;
      aout_upd <= 1'b0;
      tx_ok <= 1'b0;
      tx_word <= '0;
      sar <= '0;
    end else if (!run) begin
      cnt <= '0;
      armed <= 1'b0;
      prev_cls <= M_NONE;
      mode <= M_NONE;
      smp_stb <= 1'b0;
      step_stb <= 1'b0;
      rx_load <= 1'b0;
      tx_load <= 1'b0;
      aout_upd <= 1'b0;
      tx_ok <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (sy_rise) begin
        armed <= 1'b1;
        prev_cls <= cls;
        mode <= mode_nxt;
      end
      smp_stb  <= sy_rise && (mode_nxt == M_FULL || mode_nxt == M_ADC);
      step_stb <= cc_fall && adc_on && in_steps;
      if (cc_fall && adc_on && in_steps) begin
        step_bit <= sidx;
        sar[sidx] <= cmp_bit;
      end
      tx_load  <= end_rise && adc_on;
      aout_upd <= end_rise && dac_on;
      rx_load  <= cc_fall && dac_on && (cnt == last_n);
      if (end_rise && adc_on) tx_word <= sar;
      if (!adc_sel) tx_ok <= 1'b0;
      else if (end_rise && adc_on) tx_ok <= 1'b1;
    end
  end
endmodule

module conv_seq_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       sync_clk,
  input logic [1:0] mode,
  input logic       smp_stb,
  input logic       step_stb,
  input logic       rx_load,
  input logic       tx_load,
  input logic       tx_ok,
  input logic       aout_upd
);
  p_mode_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> $past($rose(sync_clk) || !run));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> !(smp_stb || step_stb || rx_load || tx_load || aout_upd));

  p_tx_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tx_ok);

  p_adc_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> !(rx_load || aout_upd));

  p_dac_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !(smp_stb || step_stb || tx_load || tx_ok));

  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (mode == 2'd0) && !tx_ok &&
             !(smp_stb || step_stb || rx_load || tx_load || aout_upd));
endmodule

bind conv_seq_ctl conv_seq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .sync_clk(sync_clk), .mode(mode),
  .smp_stb(smp_stb), .step_stb(step_stb), .rx_load(rx_load),
  .tx_load(tx_load), .tx_ok(tx_ok), .aout_upd(aout_upd)
);

// File: tb/conv_seq_ctl_test.sv
`timescale 1ns/1ps
module conv_seq_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b1;
  logic cvt_clk = 1'b0, sync_clk = 1'b0, cmp_bit = 1'b0;
  logic [1:0] mode;
  logic mode_ok, smp_stb, step_stb, rx_load, tx_load, tx_ok, aout_upd;
  logic [3:0] step_bit;
  logic [12:0] tx_word;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  conv_seq_ctl uut (.*);

  // entry: n[20:15], pattern[14:2], mode expected during the period[1:0]
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {6'd32, 13'h1555, 2'd0}, {6'd32, 13'h0AAA, 2'd0},
    {6'd32, 13'h1555, 2'd1}, {6'd32, 13'h0001, 2'd1},
    {6'd24, 13'h1000, 2'd1}, {6'd24, 13'h1FFF, 2'd0},
    {6'd24, 13'h0F0F, 2'd2}, {6'd24, 13'h1234, 2'd2},
    {6'd8,  13'h0000, 2'd2}, {6'd8,  13'h1FFF, 2'd0},
    {6'd8,  13'h0ABC, 2'd3}, {6'd8,  13'h0000, 2'd3},
    {6'd20, 13'h1111, 2'd3}, {6'd20, 13'h0000, 2'd0},
    {6'd32, 13'h0000, 2'd0}, {6'd32, 13'h1FFF, 2'd0},
    {6'd32, 13'h1FFF, 2'd1}, {6'd32, 13'h0800, 2'd1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string why(input bit cap, input string normal, input int m, input bit adc_side);
    if (cap) return normal;
    if (m == 0) return "R3";
    return adc_side ? "R9" : "R8";
  endfunction

  task automatic run_period(input int n, input logic [12:0] pat, input int em, input string tag);
    int c_smp = 0, c_step = 0, c_rx = 0, c_tx = 0, c_aout = 0, bad = 0;
    int nm = (em == 1) ? 32 : (em == 2) ? 24 : (em == 3) ? 8 : 0;
    bit cap_a = (em == 1 || em == 2);
    bit cap_d = (em == 1 || em == 3);
    for (int k = 1; k <= n; k++) begin
      cvt_clk = 1'b1;
      sync_clk = (k <= n / 2);
      cmp_bit = (k <= 13) ? pat[13 - k] : 1'b0;
      @(negedge clk);
      if (k == 1) chk({tag, (em == 0) ? " R3" : " R2"}, "mode", int'(mode), em);
      if (smp_stb)  begin c_smp++;  if (k != 1)  bad++; end
      if (tx_load)  begin c_tx++;   if (k != nm) bad++; end
      if (aout_upd) begin c_aout++; if (k != nm) bad++; end
      if (step_stb || rx_load) bad++;
      cvt_clk = 1'b0;
      @(negedge clk);
      if (step_stb) begin
        c_step++;
        if (int'(step_bit) != 13 - k) bad++;
      end
      if (rx_load) begin c_rx++; if (k != nm) bad++; end
      if (smp_stb || tx_load || aout_upd) bad++;
    end
    chk({tag, " ", why(cap_a, "R4", em, 1)}, "sample strobes", c_smp, cap_a ? 1 : 0);
    chk({tag, " ", why(cap_a, "R5", em, 1)}, "step strobes", c_step, cap_a ? ((n < 13) ? n : 13) : 0);
    chk({tag, " ", why(cap_a, "R6", em, 1)}, "tx loads", c_tx, (cap_a && n >= nm) ? 1 : 0);
    chk({tag, " ", why(cap_d, "R7", em, 0)}, "aout updates", c_aout, (cap_d && n >= nm) ? 1 : 0);
    chk({tag, " ", why(cap_d, "R7", em, 0)}, "rx loads", c_rx, (cap_d && n >= nm) ? 1 : 0);
    chk({tag, " R5/R6/R7"}, "strobe position errors", bad, 0);
    if (cap_a && n >= nm) begin
      chk({tag, " R5"}, "tx_word", int'(tx_word), int'(pat));
      chk({tag, " R6"}, "tx_ok", int'(tx_ok), 1);
    end
    if (em == 0 || em == 3)
      chk({tag, (em == 0) ? " R3" : " R9"}, "tx_ok", int'(tx_ok), 0);
    chk({tag, " R2"}, "mode_ok", int'(mode_ok), (em != 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "mode in reset", int'(mode), 0);
    chk("R1", "strobes in reset", int'({smp_stb, step_stb, rx_load, tx_load, aout_upd}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "mode after reset", int'(mode), 0);
    chk("R1", "mode_ok after reset", int'(mode_ok), 0);
    chk("R1", "tx_ok after reset", int'(tx_ok), 0);
    chk("R1", "tx_word after reset", int'(tx_word), 0);
    chk("R1", "strobes after reset", int'({smp_stb, step_stb, rx_load, tx_load, aout_upd}), 0);

    for (int i = 0; i < NV; i++)
      run_period(int'(VEC[i][20:15]), VEC[i][14:2], int'(VEC[i][1:0]), $sformatf("vec%0d", i));

    // power-down mid operation, then release and recovery (R10)
    run = 1'b0;
    @(negedge clk);
    chk("R10", "mode one cycle into power-down", int'(mode), 0);
    chk("R10", "tx_ok one cycle into power-down", int'(tx_ok), 0);
    run_period(32, 13'h1555, 0, "R10 halted");
    run_period(32, 13'h0AAA, 0, "R10 halted");
    run = 1'b1;
    run_period(32, 13'h1555, 0, "R10 recovery1");
    run_period(32, 13'h0AAA, 0, "R10 recovery2");
    run_period(32, 13'h1C3A, 1, "R10 resumed");
    run_period(32, 13'h0003, 1, "R10 resumed");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule